// File: doc/BRIEF.md
# Register Value Tracking Table

This block keeps a copy of every architectural register value that can be computed straight after decode. It sees one decoded micro-op per cycle, in program order. Each micro-op carries an operation kind, a destination register, a source register, a 32-bit immediate, a load flag, a write flag and a sequence tag. Simple register-plus-constant idioms are evaluated at once. Their results go into a value table, and each table entry has its own small state machine. For loads that address memory as a base register plus a displacement, the block gives an early effective address whenever the base value is known. Micro-ops whose result the tracker has already produced are flagged as executed early.

Each register entry has three states. ENT_KNOWN means the table holds the value. ENT_PENDING means the value is unknown, and the entry waits for the execution-core writeback that carries the tag of its last writer. ENT_LOST means the value is unknown and no writeback is awaited. The transitions are:
- write_known: any state goes to ENT_KNOWN when a tracked result is written.
- write_opaque: any state goes to ENT_PENDING when an untracked result is written.
- wb_hit: ENT_PENDING goes to ENT_KNOWN on a writeback with a matching tag.
- flush_drop: any state goes to ENT_LOST on a flush.
- flush_restore: any state goes to ENT_KNOWN on a flush with restore when the entry's snapshot bit is set.

Reset places every entry in ENT_LOST. Outputs are registered and appear on the cycle after the micro-op is presented. A missing address only costs an early-resolution opportunity. It is never a wrong address.

Top module: `rvt_tracker`

## Requirements
- R1: After reset all registers are unknown, ea_valid and early_done are low, and a load on any base gives no early address.
- R2: uop_kind encodes 0 add-immediate (dst=src+imm), 1 subtract-immediate (dst=src-imm), 2 address-add (dst=src+imm), 3 register move (dst=src) and 4 immediate move (dst=imm). When uop_wr=1, uop_is_load=0 and the source is known (or is not needed, for kind 4), the result is stored, the destination becomes known, and early_done is high on the next cycle.
- R3: Kind 5 (exclusive-or of a register with itself) writes zero and marks the destination known even when the source is unknown, with early_done high.
- R4: Kind 6 (or of a register with itself) copies the source value into the destination, under the same conditions as a register move.
- R5: A write by kind 7 (opaque), by a load, or by a tracked kind whose source is unknown marks the destination unknown and records its uop_tag; early_done stays low.
- R6: A load (uop_is_load=1) with a known base register uop_src gives ea_valid=1 and ea_addr=base+uop_imm (modulo 2^32) on the next cycle; with an unknown base, ea_valid stays low.
- R7: A writeback whose tag equals the recorded tag of a waiting register writes wb_data and makes the register known; a writeback with any other tag changes nothing.
- R8: A writeback that releases the source register of the micro-op in the same cycle is forwarded, so that micro-op uses wb_data as the source value.
- R9: When a micro-op writes a register in the same cycle as a writeback for that register, the micro-op's result is kept.
- R10: A flush drops the micro-op and writeback of its cycle and forces both outputs low next cycle. Every register becomes unknown with no writeback awaited, so later writebacks with old tags are ignored. With restore, each register whose snap_known bit is set instead becomes known with its snap_vals slice (register i at bits 32*i+31:32*i).
- R11: A micro-op with uop_wr=0 changes no register and gives early_done low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uop_valid | input | 1 | A decoded micro-op is presented |
| uop_kind | input | 3 | Operation kind, encoding in R2 to R5 |
| uop_wr | input | 1 | Micro-op writes its destination |
| uop_is_load | input | 1 | Micro-op is a base-plus-displacement load |
| uop_dst | input | 3 | Destination register number |
| uop_src | input | 3 | Source or base register number |
| uop_imm | input | 32 | Immediate or displacement |
| uop_tag | input | 6 | Sequence tag of the micro-op |
| wb_valid | input | 1 | Execution-core writeback present |
| wb_tag | input | 6 | Tag of the written-back micro-op |
| wb_data | input | 32 | Written-back value |
| flush | input | 1 | Pipeline flush |
| restore | input | 1 | Restore from snapshot on flush |
| snap_known | input | 8 | Snapshot known bit per register |
| snap_vals | input | 256 | Snapshot values, register i at bits 32*i+31:32*i |
| ea_valid | output | 1 | Early load address valid |
| ea_addr | output | 32 | Early load address |
| early_done | output | 1 | Result was produced by the tracker |

## Verification
Two functions can fall in the same cycle: a writeback that releases a waiting register, and a decoded micro-op that either reads that register or overwrites it. Directed cycles pair a load or move with a writeback of the matching tag, in one case for the load's base and in the other for the move's destination. The random phase sends a writeback of a pending register's tag in most cycles while micro-ops pick registers at random, so both collisions happen often. Each is judged on the early address or on a later load of the register, against a bench model that forwards the writeback to the reader and lets the writer win.

// File: rtl/rvt_pkg.sv
package rvt_pkg;
    typedef enum logic [2:0] {
        K_ADDI   = 3'd0,
        K_SUBI   = 3'd1,
        K_LEA    = 3'd2,
        K_MOVR   = 3'd3,
        K_MOVI   = 3'd4,
        K_XORS   = 3'd5,
        K_ORS    = 3'd6,
        K_OPAQUE = 3'd7
    } uop_kind_e;

    typedef enum logic [1:0] {
        ENT_LOST    = 2'd0,
        ENT_PENDING = 2'd1,
        ENT_KNOWN   = 2'd2
    } ent_state_e;
endpackage

// File: rtl/rvt_eval.sv
module rvt_eval
    import rvt_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  uop_kind_e         kind_i,
    input  logic              is_load_i,
    input  logic              src_known_i,
    input  logic [XLEN-1:0]   src_val_i,
    input  logic [XLEN-1:0]   imm_i,
    output logic              res_known_o,
    output logic [XLEN-1:0]   res_val_o
);
    always_comb begin
        res_known_o = 1'b0;
        res_val_o   = '0;
        unique case (kind_i)
            K_ADDI: begin
                res_known_o = src_known_i;
                res_val_o   = src_val_i + imm_i;
            end
            K_SUBI: begin
                res_known_o = src_known_i;
                res_val_o   = src_val_i - imm_i;
            end
            K_LEA: begin
                res_known_o = src_known_i;
                res_val_o   = src_val_i + imm_i;
            end
            K_MOVR, K_ORS: begin
                res_known_o = src_known_i;
                res_val_o   = src_val_i;
            end
            K_MOVI: begin
                res_known_o = 1'b1;
                res_val_o   = imm_i;
            end
            K_XORS: begin
                res_known_o = 1'b1;
                res_val_o   = '0;
            end
            K_OPAQUE: begin
                res_known_o = 1'b0;
                res_val_o   = '0;
            end
        endcase
        if (is_load_i) begin
            res_known_o = 1'b0;
        end
    end
endmodule

// File: rtl/rvt_entry.sv
module rvt_entry
    import rvt_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int TAGW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush_i,
    input  logic            restore_i,
    input  logic            snap_known_i,
    input  logic [XLEN-1:0] snap_val_i,
    input  logic            wr_en_i,
    input  logic            wr_known_i,
    input  logic [XLEN-1:0] wr_val_i,
    input  logic [TAGW-1:0] wr_tag_i,
    input  logic            wb_valid_i,
    input  logic [TAGW-1:0] wb_tag_i,
    input  logic [XLEN-1:0] wb_data_i,
    output ent_state_e      state_o,
    output logic [XLEN-1:0] val_o,
    output logic [TAGW-1:0] tag_o
);
    ent_state_e      st_q, st_d;
    logic [XLEN-1:0] val_q, val_d;
    logic [TAGW-1:0] tag_q, tag_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ENT_LOST;
            val_q <= '0;
            tag_q <= '0;
        end else begin
            st_q  <= st_d;
            val_q <= val_d;
            tag_q <= tag_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        val_d = val_q;
        tag_d = tag_q;
        if (flush_i) begin
            if (restore_i && snap_known_i) begin
                st_d  = ENT_KNOWN;           // flush_restore
                val_d = snap_val_i;
            end else begin
                st_d  = ENT_LOST;            // flush_drop
            end
        end else if (wr_en_i) begin
            if (wr_known_i) begin
                st_d  = ENT_KNOWN;           // write_known
                val_d = wr_val_i;
            end else begin
                st_d  = ENT_PENDING;         // write_opaque
                tag_d = wr_tag_i;
            end
        end else begin
            unique case (st_q)
                ENT_PENDING: begin
                    if (wb_valid_i && (wb_tag_i == tag_q)) begin
                        st_d  = ENT_KNOWN;   // wb_hit
                        val_d = wb_data_i;
                    end
                end
                ENT_KNOWN, ENT_LOST: begin
                    st_d = st_q;
                end
                default: st_d = ENT_LOST;
            endcase
        end
    end

    assign state_o = st_q;
    assign val_o   = val_q;
    assign tag_o   = tag_q;
endmodule

// File: rtl/rvt_tracker.sv
module rvt_tracker
    import rvt_pkg::*;
#(
    parameter int NREGS = 8,
    parameter int XLEN  = 32,
    parameter int TAGW  = 6,
    localparam int RIDX = $clog2(NREGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  uop_valid,
    input  logic [2:0]            uop_kind,
    input  logic                  uop_wr,
    input  logic                  uop_is_load,
    input  logic [RIDX-1:0]       uop_dst,
    input  logic [RIDX-1:0]       uop_src,
    input  logic [XLEN-1:0]       uop_imm,
    input  logic [TAGW-1:0]       uop_tag,
    input  logic                  wb_valid,
    input  logic [TAGW-1:0]       wb_tag,
    input  logic [XLEN-1:0]       wb_data,
    input  logic                  flush,
    input  logic                  restore,
    input  logic [NREGS-1:0]      snap_known,
    input  logic [NREGS*XLEN-1:0] snap_vals,
    output logic                  ea_valid,
    output logic [XLEN-1:0]       ea_addr,
    output logic                  early_done
);
    ent_state_e      ent_st  [NREGS];
    logic [XLEN-1:0] ent_val [NREGS];
    logic [TAGW-1:0] ent_tag [NREGS];

    logic            src_hit, src_known;
    logic [XLEN-1:0] src_val;
    logic            res_known;
    logic [XLEN-1:0] res_val;
    logic            take_uop;

    assign take_uop = uop_valid && !flush;

    // source read with writeback forwarding
    always_comb begin
        src_hit   = wb_valid && (ent_st[uop_src] == ENT_PENDING)
                    && (ent_tag[uop_src] == wb_tag);
        src_known = (ent_st[uop_src] == ENT_KNOWN) || src_hit;
        src_val   = src_hit ? wb_data : ent_val[uop_src];
    end

    rvt_eval #(.XLEN(XLEN)) u_eval (
        .kind_i      (uop_kind_e'(uop_kind)),
        .is_load_i   (uop_is_load),
        .src_known_i (src_known),
        .src_val_i   (src_val),
        .imm_i       (uop_imm),
        .res_known_o (res_known),
        .res_val_o   (res_val)
    );

    for (genvar gi = 0; gi < NREGS; gi++) begin : g_ent
        logic wr_en;
        assign wr_en = take_uop && uop_wr && (uop_dst == RIDX'(gi));
        rvt_entry #(.XLEN(XLEN), .TAGW(TAGW)) u_ent (
            .clk          (clk),
            .rst_n        (rst_n),
            .flush_i      (flush),
            .restore_i    (restore),
            .snap_known_i (snap_known[gi]),
            .snap_val_i   (snap_vals[gi*XLEN +: XLEN]),
            .wr_en_i      (wr_en),
            .wr_known_i   (res_known),
            .wr_val_i     (res_val),
            .wr_tag_i     (uop_tag),
            .wb_valid_i   (wb_valid),
            .wb_tag_i     (wb_tag),
            .wb_data_i    (wb_data),
            .state_o      (ent_st[gi]),
            .val_o        (ent_val[gi]),
            .tag_o        (ent_tag[gi])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ea_valid   <= 1'b0;
            ea_addr    <= '0;
            early_done <= 1'b0;
        end else begin
            ea_valid   <= uop_valid && uop_is_load && src_known;
            ea_addr    <= src_val + uop_imm;
            early_done <= uop_valid && uop_wr && res_known;
        end
    end
endmodule

// File: rtl/rvt_tracker_chk.sv
module rvt_tracker_chk
    import rvt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       uop_valid,
    input logic [2:0] uop_kind,
    input logic       uop_wr,
    input logic       uop_is_load,
    input logic       flush,
    input logic       ea_valid,
    input logic       early_done
);
    // R2
    done_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        early_done |-> $past(uop_valid && uop_wr && !uop_is_load && !flush
                             && (uop_kind != 3'd7)));
    // R6
    ea_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ea_valid |-> $past(uop_valid && uop_is_load && !flush));
    // R10
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> (!ea_valid && !early_done));
    // R3
    xor_zero_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(uop_valid && uop_wr && !uop_is_load && !flush && (uop_kind == 3'd5))
        |-> early_done);
    // R11
    nowrite_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(uop_valid && !uop_wr) |-> !early_done);
    // R6
    exclusive_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ea_valid && early_done));
endmodule

bind rvt_tracker rvt_tracker_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .uop_valid   (uop_valid),
    .uop_kind    (uop_kind),
    .uop_wr      (uop_wr),
    .uop_is_load (uop_is_load),
    .flush       (flush),
    .ea_valid    (ea_valid),
    .early_done  (early_done)
);

// File: tb/rvt_tracker_bench.sv
`timescale 1ns/1ps
module rvt_tracker_bench;
    localparam int CLKP = 20;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        uop_valid, uop_wr, uop_is_load;
    logic [2:0]  uop_kind, uop_dst, uop_src;
    logic [31:0] uop_imm;
    logic [5:0]  uop_tag;
    logic        wb_valid;
    logic [5:0]  wb_tag;
    logic [31:0] wb_data;
    logic        flush, restore;
    logic [7:0]  snap_known;
    logic [255:0] snap_vals;
    logic        ea_valid, early_done;
    logic [31:0] ea_addr;

    always #(CLKP/2) clk = ~clk;

    rvt_tracker u_rvt_tracker (
        .clk(clk), .rst_n(rst_n), .uop_valid(uop_valid), .uop_kind(uop_kind),
        .uop_wr(uop_wr), .uop_is_load(uop_is_load), .uop_dst(uop_dst),
        .uop_src(uop_src), .uop_imm(uop_imm), .uop_tag(uop_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .flush(flush), .restore(restore), .snap_known(snap_known),
        .snap_vals(snap_vals), .ea_valid(ea_valid), .ea_addr(ea_addr),
        .early_done(early_done)
    );

    int total = 0, bad = 0;
    bit finished = 0;

    // model: 0 lost, 1 pending, 2 known
    int          m_st  [8];
    logic [31:0] m_val [8];
    logic [5:0]  m_tag [8];
    logic [5:0]  seq = 0;
    logic [5:0]  last_tag;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        uop_valid = 0; uop_kind = 0; uop_wr = 0; uop_is_load = 0;
        uop_dst = 0; uop_src = 0; uop_imm = 0; uop_tag = 0;
        wb_valid = 0; wb_tag = 0; wb_data = 0;
        flush = 0; restore = 0; snap_known = 0;
    endtask

    // one cycle: drive at negedge, check outputs at the following negedge
    task automatic cyc(input string req, input logic v, input logic [2:0] k,
                       input logic wr, input logic ld, input logic [2:0] d,
                       input logic [2:0] s, input logic [31:0] imm,
                       input logic wbv, input logic [5:0] wbt,
                       input logic [31:0] wbd, input logic fl,
                       input logic rs, input logic [7:0] sk);
        logic hit, skn, rk, e_ea, e_done;
        logic [31:0] sv, rv, e_addr;
        uop_valid = v; uop_kind = k; uop_wr = wr; uop_is_load = ld;
        uop_dst = d; uop_src = s; uop_imm = imm; uop_tag = seq;
        last_tag = seq;
        if (v) seq = seq + 1;
        wb_valid = wbv; wb_tag = wbt; wb_data = wbd;
        flush = fl; restore = rs; snap_known = sk;
        e_ea = 0; e_done = 0; e_addr = 0;
        if (fl) begin
            for (int r = 0; r < 8; r++) begin
                if (rs && sk[r]) begin m_st[r] = 2; m_val[r] = snap_vals[r*32 +: 32]; end
                else m_st[r] = 0;
            end
        end else begin
            hit = wbv && m_st[s] == 1 && m_tag[s] == wbt;
            skn = (m_st[s] == 2) || hit;
            sv  = hit ? wbd : m_val[s];
            rk = 0; rv = 0;
            case (k)
                3'd0, 3'd2: begin rk = skn; rv = sv + imm; end
                3'd1: begin rk = skn; rv = sv - imm; end
                3'd3, 3'd6: begin rk = skn; rv = sv; end
                3'd4: begin rk = 1; rv = imm; end
                3'd5: begin rk = 1; rv = 0; end
                default: rk = 0;
            endcase
            if (ld) rk = 0;
            e_ea = v && ld && skn;
            e_addr = sv + imm;
            e_done = v && wr && rk;
            for (int r = 0; r < 8; r++)
                if (wbv && m_st[r] == 1 && m_tag[r] == wbt) begin
                    m_st[r] = 2; m_val[r] = wbd;
                end
            if (v && wr) begin
                if (rk) begin m_st[d] = 2; m_val[d] = rv; end
                else begin m_st[d] = 1; m_tag[d] = last_tag; end
            end
        end
        @(negedge clk);
        chk(req, "ea_valid", {31'b0, ea_valid}, {31'b0, e_ea});
        if (e_ea) chk(req, "ea_addr", ea_addr, e_addr);
        chk(req, "early_done", {31'b0, early_done}, {31'b0, e_done});
    endtask

    task automatic op(input string req, input logic [2:0] k,
                      input logic [2:0] d, input logic [2:0] s, input logic [31:0] imm);
        cyc(req, 1, k, 1, 0, d, s, imm, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic ld(input string req, input logic [2:0] s, input logic [31:0] imm);
        cyc(req, 1, 3'd7, 0, 1, 0, s, imm, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLKP * 200000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end

    initial begin
        logic [5:0] t;
        void'($urandom(32'd1234));
        idle_inputs();
        snap_vals = '0;
        for (int r = 0; r < 8; r++) begin m_st[r] = 0; m_val[r] = 0; m_tag[r] = 0; end
        rst_n = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "ea_valid", {31'b0, ea_valid}, 0);
        chk("R1", "early_done", {31'b0, early_done}, 0);
        rst_n = 1;
        ld("R1", 3'd0, 32'd4);
        // R2 tracked forms, R6 early address
        op("R2", 3'd4, 3'd1, 3'd0, 32'd100);
        ld("R6", 3'd1, 32'd4);
        op("R2", 3'd0, 3'd2, 3'd1, 32'd5);
        op("R2", 3'd1, 3'd3, 3'd1, 32'd1);
        op("R2", 3'd2, 3'd4, 3'd1, 32'h10);
        op("R2", 3'd3, 3'd5, 3'd4, 32'd0);
        ld("R2", 3'd2, 32'd0);
        ld("R2", 3'd3, 32'hFFFF_FFFF);
        ld("R2", 3'd5, 32'd8);
        // R5 opaque and unknown source
        op("R5", 3'd7, 3'd6, 3'd0, 32'd0);
        ld("R5", 3'd6, 32'd0);
        op("R5", 3'd0, 3'd7, 3'd6, 32'd1);
        t = last_tag;
        ld("R5", 3'd7, 32'd0);
        // R3 xor self on unknown source, R4 or self
        op("R3", 3'd5, 3'd6, 3'd6, 32'd0);
        ld("R3", 3'd6, 32'd12);
        op("R4", 3'd6, 3'd0, 3'd2, 32'd0);
        ld("R4", 3'd0, 32'd1);
        // R7 wrong tag ignored, right tag releases
        cyc("R7", 0, 0, 0, 0, 0, 0, 0, 1, t + 6'd1, 32'd55, 0, 0, 0);
        ld("R7", 3'd7, 32'd0);
        cyc("R7", 0, 0, 0, 0, 0, 0, 0, 1, t, 32'd300, 0, 0, 0);
        ld("R7", 3'd7, 32'd2);
        // R8 forwarding to a load base
        op("R8", 3'd7, 3'd5, 3'd0, 32'd0);
        t = last_tag;
        cyc("R8", 1, 3'd7, 0, 1, 0, 3'd5, 32'd8, 1, t, 32'd500, 0, 0, 0);
        // R9 writer wins over same-cycle writeback
        op("R9", 3'd7, 3'd4, 3'd0, 32'd0);
        t = last_tag;
        cyc("R9", 1, 3'd4, 1, 0, 3'd4, 3'd0, 32'd7, 1, t, 32'd99, 0, 0, 0);
        ld("R9", 3'd4, 32'd0);
        // R11 no write
        cyc("R11", 1, 3'd0, 0, 0, 3'd1, 3'd1, 32'd9, 0, 0, 0, 0, 0, 0);
        ld("R11", 3'd1, 32'd4);
        // R10 flush with restore, uop in same cycle dropped
        snap_vals = '0;
        snap_vals[31:0] = 32'h1000;
        snap_vals[63:32] = 32'h2000;
        cyc("R10", 1, 3'd4, 1, 0, 3'd2, 3'd0, 32'd1, 0, 0, 0, 1, 1, 8'h03);
        ld("R10", 3'd0, 32'd4);
        ld("R10", 3'd1, 32'd0);
        ld("R10", 3'd2, 32'd0);
        // R10 flush without restore, stale writeback ignored
        op("R10", 3'd7, 3'd3, 3'd0, 32'd0);
        t = last_tag;
        cyc("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 8'hFF);
        cyc("R10", 0, 0, 0, 0, 0, 0, 0, 1, t, 32'd77, 0, 0, 0);
        ld("R10", 3'd3, 32'd0);
        ld("R10", 3'd0, 32'd0);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic v, wr, l, wbv, fl, rs;
            logic [2:0] k, d, s, pr;
            logic [31:0] imm, wbd;
            logic [5:0] wbt;
            v = ($urandom % 8) != 0;
            k = 3'($urandom % 8);
            l = ($urandom % 3) == 0;
            wr = ($urandom % 6) != 0;
            d = 3'($urandom); s = 3'($urandom);
            imm = (($urandom % 2) == 0) ? ($urandom % 64) : $urandom;
            pr = 3'($urandom);
            wbv = ($urandom % 3) != 0;
            wbt = (m_st[pr] == 1 && ($urandom % 5) != 0) ? m_tag[pr] : 6'($urandom);
            wbd = $urandom;
            fl = ($urandom % 97) == 0;
            rs = $urandom % 2;
            snap_vals = {$urandom, $urandom, $urandom, $urandom,
                         $urandom, $urandom, $urandom, $urandom};
            cyc(l ? "R6" : "R2", v, k, wr, l, d, s, imm, wbv, wbt, wbd, fl, rs,
                8'($urandom));
        end
        idle_inputs();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule